// File: doc/BRIEF.md
# DMA Address Remapping Page Walker

This block turns a DMA request from a device into a system physical address by reading translation tables held in memory. A request carries a 16-bit requester ID and a 48-bit DMA virtual address. The walk starts at a device-table base supplied as an input. The bus number selects a root entry. The device and function numbers then select a per-device context entry, which holds the root of that device's four-level page table. Four 9-bit slices of the virtual address then index the page-table levels in turn.

Each table access is a single 64-bit read issued on a valid/ready read port. The read data may come back any number of cycles later. When every entry is present, the block returns the page frame from the leaf entry joined to the untranslated 12-bit page offset. When an entry is not present, the walk stops at once and the block reports a fault instead. The fault names the level where the walk stopped and the requester ID. Only one walk is in flight at a time.

Top module: `dma_remap_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_rd_valid` and `rsp_valid` are 0.
- R2: `req_ready` goes to 0 in the cycle after a request is accepted. It stays 0 until the cycle that follows the `rsp_valid` pulse. While it is 0, `req_valid`, `req_rid` and `req_va` have no effect on the walk in progress.
- R3: The first table read is at address `dt_base + bus*8`, where bus is `req_rid[15:8]`.
- R4: The second read is at `{E[51:12],12'b0} + {dev,func}*8`. Here E is the root entry that was read, dev is `req_rid[7:3]` and func is `req_rid[2:0]`.
- R5: Reads three to six go to the page-table levels 4, 3, 2 and 1. Each is at `{E[51:12],12'b0} + idx*8`, where E is the previous entry. The values of idx are `req_va[47:39]`, `[38:30]`, `[29:21]` and `[20:12]`, in that order. Entry bits 63:52 and 11:1 are ignored.
- R6: A walk whose six entries all have bit 0 set ends with `rsp_fault`=0 and `rsp_level`=0. It also gives `rsp_paddr = {leaf[51:12], req_va[11:0]}`.
- R7: An entry with bit 0 clear ends the walk with no further reads. The result then has `rsp_fault`=1, `rsp_paddr`=0 and `rsp_rid` equal to the requester ID. `rsp_level` gives the step that failed: 6 for root, 5 for context, and 4, 3, 2 or 1 for a page-table level.
- R8: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request holds and its address does not change. Any delay between a read's acceptance and its response gives the same result.
- R9: `rsp_valid` is a one-cycle pulse, delivered the cycle after the final response. `rsp_rid` always carries the requester ID of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rid | input | 16 | Requester ID: bus, device, function |
| req_va | input | 48 | DMA virtual address |
| dt_base | input | PA_W | Device-table base address |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Table read accepted |
| mem_rd_addr | output | PA_W | Table read byte address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk hit a non-present entry |
| rsp_level | output | 3 | Fault step code (0 on success) |
| rsp_rid | output | 16 | Requester ID of the walk |
| rsp_paddr | output | PA_W | Translated physical address |

## Verification
Directed walks place the non-present entry at each of the six steps in turn. This separates the root, context and four page-level fault codes, and shows that no read follows a fault. Extreme values of the requester ID and the address (all ones, all zeros) check the index slicing and the scaling by 8. The entries carry random junk in their reserved bits, which shows that only bits 51:12 form the next base. Random walks add random stall and response delays on the read port. One walk keeps `req_valid` high with a different ID throughout, which shows that new requests are ignored while a walk is busy.

// File: rtl/dma_remap_walker.sv
module dma_remap_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [15:0]     req_rid,
  input  logic [47:0]     req_va,
  input  logic [PA_W-1:0] dt_base,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [2:0]      rsp_level,
  output logic [15:0]     rsp_rid,
  output logic [PA_W-1:0] rsp_paddr
);
  localparam int FR_W = PA_W - 12;
  localparam logic [2:0] LAST_STEP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t             st;
  logic [2:0]      step;
  logic [PA_W-1:0] base;
  logic [15:0]     rid_q;
  logic [47:0]     va_q;
  logic            fault_q;
  logic [2:0]      level_q;
  logic [PA_W-1:0] paddr_q;
  logic [8:0]      idx;
  logic [FR_W-1:0] frame;
  logic            accept;

  always_comb begin
    case (step)
      3'd0:    idx = {1'b0, rid_q[15:8]};
      3'd1:    idx = {1'b0, rid_q[7:0]};
      3'd2:    idx = va_q[47:39];
      3'd3:    idx = va_q[38:30];
      3'd4:    idx = va_q[29:21];
      default: idx = va_q[20:12];
    endcase
  end

  assign frame        = mem_rsp_data[PA_W-1:12];
  assign accept       = req_valid && req_ready;
  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_ISSUE);
  assign mem_rd_addr  = base + {{(PA_W-12){1'b0}}, idx, 3'b000};
  assign rsp_valid    = (st == S_DONE);
  assign rsp_fault    = fault_q;
  assign rsp_level    = level_q;
  assign rsp_rid      = rid_q;
  assign rsp_paddr    = paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      base    <= '0;
      rid_q   <= '0;
      va_q    <= '0;
      fault_q <= 1'b0;
      level_q <= '0;
      paddr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st    <= S_ISSUE;
          step  <= '0;
          base  <= dt_base;
          rid_q <= req_rid;
          va_q  <= req_va;
        end
        S_ISSUE: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fault_q <= 1'b1;
            level_q <= 3'd6 - step;
            paddr_q <= '0;
            st      <= S_DONE;
          end else if (step == LAST_STEP) begin
            fault_q <= 1'b0;
            level_q <= 3'd0;
            paddr_q <= {frame, va_q[11:0]};
            st      <= S_DONE;
          end else begin
            base <= {frame, 12'h000};
            step <= step + 3'd1;
            st   <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_ready_after_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  p_no_read_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);
  p_read_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_ok_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_level == 3'd0 && rsp_paddr[11:0] == va_q[11:0]));
  p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_level >= 3'd1 && rsp_level <= 3'd6 && rsp_paddr == '0));
  p_no_read_on_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_valid);
endmodule

// File: tb/dma_remap_walker_bench.sv
module dma_remap_walker_bench;
  localparam int CLK_NS = 10;
  localparam int WD_CYC = 150000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [15:0] req_rid = 0;
  logic [47:0] req_va = 0;
  logic [51:0] dt_base = 0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 0;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = 0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_level;
  logic [15:0] rsp_rid;
  logic [51:0] rsp_paddr;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_remap_walker #(.PA_W(52)) u_dma_remap_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rid(req_rid), .req_va(req_va), .dt_base(dt_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_rid(rsp_rid), .rsp_paddr(rsp_paddr));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] step_idx(input logic [15:0] rid, input logic [47:0] va, input int k);
    case (k)
      0: return {1'b0, rid[15:8]};
      1: return {1'b0, rid[7:0]};
      2: return va[47:39];
      3: return va[38:30];
      4: return va[29:21];
      default: return va[20:12];
    endcase
  endfunction

  task automatic run_walk(input logic [15:0] rid, input logic [47:0] va, input int fstep,
                          input bit hold, input int maxdly);
    logic [51:0] exp_addr [6];
    logic [63:0] ent [6];
    logic [51:0] cur;
    logic [39:0] fr;
    int last;
    int n;
    dt_base = {$urandom(), $urandom()};
    cur = dt_base;
    for (int k = 0; k < 6; k++) begin
      exp_addr[k] = cur + {40'h0, step_idx(rid, va, k), 3'b000};
      fr = {$urandom(), $urandom()};
      ent[k] = {12'($urandom()), fr, 11'($urandom()), (k != fstep)};
      cur = {fr, 12'h000};
    end
    last = (fstep < 6) ? fstep : 5;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'h1);
    req_valid = 1; req_rid = rid; req_va = va;
    @(negedge clk);
    if (hold) begin req_rid = ~rid; req_va = ~va; end
    else req_valid = 0;
    chk(req_ready == 1'b0, "R2 ready low after accept", 64'(req_ready), 64'h0);
    for (int k = 0; k <= last; k++) begin
      n = 0;
      while (!mem_rd_valid && n < 50) begin @(negedge clk); n++; end
      chk(mem_rd_valid == 1'b1, "R8 read issued", 64'(mem_rd_valid), 64'h1);
      chk(mem_rd_addr == exp_addr[k], (k == 0) ? "R3 root read addr" :
          (k == 1) ? "R4 context read addr" : "R5 page read addr",
          64'(mem_rd_addr), 64'(exp_addr[k]));
      for (int d = 0; d < int'($urandom_range(maxdly)); d++) begin
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == exp_addr[k], "R8 read held while stalled",
            64'(mem_rd_addr), 64'(exp_addr[k]));
      end
      mem_rd_ready = 1;
      @(negedge clk);
      mem_rd_ready = 0;
      if (hold) req_valid = 0;
      for (int d = 0; d < int'($urandom_range(maxdly)); d++) @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = ent[k];
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = {$urandom(), $urandom()};
      if (k < last) chk(req_ready == 1'b0, "R2 ready low mid-walk", 64'(req_ready), 64'h0);
    end
    chk(rsp_valid == 1'b1, "R9 result pulse", 64'(rsp_valid), 64'h1);
    chk(rsp_rid == rid, "R9 result rid", 64'(rsp_rid), 64'(rid));
    if (fstep < 6) begin
      chk(rsp_fault == 1'b1, "R7 fault flag", 64'(rsp_fault), 64'h1);
      chk(rsp_level == 3'(6 - fstep), "R7 fault level", 64'(rsp_level), 64'(6 - fstep));
      chk(rsp_paddr == 52'h0, "R7 fault paddr zero", 64'(rsp_paddr), 64'h0);
      chk(mem_rd_valid == 1'b0, "R7 no read after fault", 64'(mem_rd_valid), 64'h0);
    end else begin
      chk(rsp_fault == 1'b0, "R6 no fault", 64'(rsp_fault), 64'h0);
      chk(rsp_level == 3'd0, "R6 level zero", 64'(rsp_level), 64'h0);
      chk(rsp_paddr == {ent[5][51:12], va[11:0]}, "R6 translated address",
          64'(rsp_paddr), 64'({ent[5][51:12], va[11:0]}));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 pulse one cycle", 64'(rsp_valid), 64'h0);
    chk(req_ready == 1'b1, "R2 ready after result", 64'(req_ready), 64'h1);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", WD_CYC);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'h1);
    chk(mem_rd_valid == 1'b0, "R1 reset no read", 64'(mem_rd_valid), 64'h0);
    chk(rsp_valid == 1'b0, "R1 reset no result", 64'(rsp_valid), 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !mem_rd_valid, "R1 idle after reset", 64'(req_ready), 64'h1);
    run_walk(16'h1234, 48'h1234_5678_9abc, 6, 0, 0);
    run_walk(16'hffff, 48'hffff_ffff_ffff, 6, 0, 2);
    run_walk(16'h0000, 48'h0000_0000_0000, 6, 0, 2);
    for (int f = 0; f < 6; f++)
      run_walk(16'($urandom()), {$urandom(), 16'($urandom())}, f, 0, 3);
    run_walk(16'hab5c, 48'h8000_4020_1fff, 6, 1, 2);
    run_walk(16'h00ff, 48'h7fc0_3fe0_1ff0, 2, 1, 1);
    for (int t = 0; t < 60; t++)
      run_walk(16'($urandom()), {$urandom(), 16'($urandom())},
               ($urandom_range(3) == 0) ? int'($urandom_range(5)) : 6, t[0], 4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule